// File: doc/BRIEF.md
# Write-Protect Command Sequence Detector

This block sits behind the page-load front end of a parallel non-volatile memory. It sees every latched byte write as an address/data pair. It recognises two fixed command sequences. The first is a three-step unlock prefix, which arms protection. The second is a six-step sequence, which removes protection. The block holds the protect flag and tells the write sequencer, one byte at a time, whether that byte may be committed to the array.

A load window opens with the first accepted byte. It closes when the byte-load timeout fires. The internal write cycle then runs until the sequencer reports that it is done. Command bytes are never stored. A flag change requested inside a window takes effect only at the end of that window's write cycle. Matching is possible only from the first byte of a window, and it stops at the first byte that breaks the expected order. The value the flag has after a reset comes from an input that models the flag kept across power cycles.

Top module: `wp_cmd_detect`

## Requirements
- R1: During reset `prot_flag` takes the value of `prot_init`. After reset `busy` is 0, and `wr_commit` and `wr_discard` are 0 until a byte is loaded.
- R2: A byte loaded with `ld_valid` while not busy produces exactly one pulse in the next cycle: `wr_commit` if it is to be stored, `wr_discard` otherwise. The two are never high together.
- R3: The unlock prefix is the pairs (data 0xAA at address 0x1555), (0x55 at 0x0AAA), (0xA0 at 0x1555), loaded as the first three bytes of a window. Every byte the matcher consumes pulses `wr_discard`. This includes the matched steps of a sequence that later breaks.
- R4: The remove sequence is (0xAA at 0x1555), (0x55 at 0x0AAA), (0x80 at 0x1555), (0xAA at 0x1555), (0x55 at 0x0AAA), (0x20 at 0x1555), loaded from the start of a window.
- R5: A byte that breaks the expected order stops matching for the rest of the window. That byte, and every later byte in the window, is user data.
- R6: With `prot_flag` at 0, every user byte is committed.
- R7: With `prot_flag` at 1, user bytes are discarded unless the window began with a complete unlock or remove sequence. When it did, every user byte after the sequence is committed.
- R8: A completed unlock prefix sets `prot_flag`, and a completed remove sequence clears it. The change happens in the cycle after `cyc_done` ends that window's write cycle, and it happens even when no user byte followed. `prot_flag` changes at no other time.
- R9: `win_timeout` while a window is open sets `busy` from the next cycle. A timeout with no open window does nothing. A window of discarded bytes still starts the write cycle.
- R10: `cyc_done` while busy clears `busy` in the next cycle. Bytes loaded while busy give no pulse and do not advance the matcher.
- R11: A timeout partway through a sequence aborts the match. The flag is unchanged, and the next window matches from its first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prot_init | input | 1 | Flag value loaded during reset (retained state) |
| ld_valid | input | 1 | One-cycle strobe: a byte write was latched |
| ld_addr | input | ADDR_W | Address of the latched byte |
| ld_data | input | DATA_W | Data of the latched byte |
| win_timeout | input | 1 | Byte-load timeout: the current load window closes |
| cyc_done | input | 1 | The internal write cycle has finished |
| wr_commit | output | 1 | Pulse: the byte loaded last cycle is to be stored |
| wr_discard | output | 1 | Pulse: the byte loaded last cycle is not stored |
| busy | output | 1 | Write cycle in progress |
| prot_flag | output | 1 | Write protection active |

## Verification
On every cycle the assertions check these rules:
- commit and discard are exclusive, and each pulse follows a load;
- loads during busy are ignored;
- busy rises only after a timeout and falls only after a done;
- the flag changes only right after a done that ends a busy cycle, and it takes `prot_init` out of reset.

Some behaviour needs the bench's scenarios:
- whether a given byte is classified as command or user data;
- whether a completed unlock or remove sequence moves the flag in the right direction;
- whether a broken or timed-out partial sequence leaves the flag alone and lets the next window match afresh.

Only a reference model run alongside long byte streams can show these.

// File: rtl/wpd_pkg.sv
package wpd_pkg;
  typedef enum logic [1:0] {
    HIT_NONE = 2'd0,
    HIT_STEP = 2'd1,
    HIT_LOCK = 2'd2,
    HIT_FREE = 2'd3
  } hit_e;

  localparam int unsigned SEQ_LEN  = 6;
  localparam int unsigned STEP_W   = 3;
  localparam int unsigned FORK_IDX = 2;
endpackage

// File: rtl/wpd_matcher.sv
module wpd_matcher
  import wpd_pkg::*;
#(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] ADR_P = 13'h1555,
  parameter logic [ADDR_W-1:0] ADR_Q = 13'h0AAA,
  parameter logic [DATA_W-1:0] KEY_1 = 8'hAA,
  parameter logic [DATA_W-1:0] KEY_2 = 8'h55,
  parameter logic [DATA_W-1:0] KEY_LOCK = 8'hA0,
  parameter logic [DATA_W-1:0] KEY_3 = 8'h80,
  parameter logic [DATA_W-1:0] KEY_FREE = 8'h20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              byte_ev,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output hit_e              hit,
  output logic              is_cmd
);
  localparam int unsigned TBL = 2 ** STEP_W;

  logic [ADDR_W-1:0] exp_a [TBL];
  logic [DATA_W-1:0] exp_d [TBL];
  logic [STEP_W-1:0] step;
  logic              live;

  for (genvar i = 0; i < TBL; i++) begin : g_tbl
    if (i == 1 || i == 4) begin : g_q
      assign exp_a[i] = ADR_Q;
      assign exp_d[i] = KEY_2;
    end else if (i == 2) begin : g_fork
      assign exp_a[i] = ADR_P;
      assign exp_d[i] = KEY_3;
    end else if (i == 5) begin : g_last
      assign exp_a[i] = ADR_P;
      assign exp_d[i] = KEY_FREE;
    end else if (i < SEQ_LEN) begin : g_p
      assign exp_a[i] = ADR_P;
      assign exp_d[i] = KEY_1;
    end else begin : g_pad
      assign exp_a[i] = '1;
      assign exp_d[i] = '0;
    end
  end

  logic base_ok, lock_ok;
  assign base_ok = (addr == exp_a[step]) && (data == exp_d[step]);
  assign lock_ok = (step == STEP_W'(FORK_IDX)) && (addr == ADR_P) && (data == KEY_LOCK);

  always_comb begin
    hit = HIT_NONE;
    if (byte_ev && live) begin
      if (lock_ok)
        hit = HIT_LOCK;
      else if (base_ok)
        hit = (step == STEP_W'(SEQ_LEN - 1)) ? HIT_FREE : HIT_STEP;
    end
  end

  assign is_cmd = (hit != HIT_NONE);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      step <= '0;
      live <= 1'b1;
    end else if (byte_ev && live) begin
      if (hit == HIT_STEP)
        step <= step + 1'b1;
      else
        live <= 1'b0;
    end
  end
endmodule

// File: rtl/wpd_window.sv
module wpd_window
  import wpd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ld_valid,
  input  logic win_timeout,
  input  logic cyc_done,
  input  hit_e hit,
  output logic accept,
  output logic cyc_end,
  output logic busy,
  output logic auth,
  output logic pend_set,
  output logic pend_clr
);
  logic open_q;

  assign accept  = ld_valid && !busy && !win_timeout;
  assign cyc_end = cyc_done && busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q   <= 1'b0;
      busy     <= 1'b0;
      auth     <= 1'b0;
      pend_set <= 1'b0;
      pend_clr <= 1'b0;
    end else begin
      if (accept) begin
        open_q <= 1'b1;
        if (hit == HIT_LOCK) begin
          auth     <= 1'b1;
          pend_set <= 1'b1;
        end else if (hit == HIT_FREE) begin
          auth     <= 1'b1;
          pend_clr <= 1'b1;
        end
      end
      if (win_timeout && open_q) begin
        open_q <= 1'b0;
        busy   <= 1'b1;
      end
      if (cyc_end) begin
        busy     <= 1'b0;
        auth     <= 1'b0;
        pend_set <= 1'b0;
        pend_clr <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/wpd_flag.sv
module wpd_flag (
  input  logic clk,
  input  logic rst,
  input  logic prot_init,
  input  logic cyc_end,
  input  logic pend_set,
  input  logic pend_clr,
  output logic prot_flag
);
  always_ff @(posedge clk) begin
    if (rst)
      prot_flag <= prot_init;
    else if (cyc_end && pend_set)
      prot_flag <= 1'b1;
    else if (cyc_end && pend_clr)
      prot_flag <= 1'b0;
  end
endmodule

// File: rtl/wp_cmd_detect.sv
module wp_cmd_detect
  import wpd_pkg::*;
#(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prot_init,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              win_timeout,
  input  logic              cyc_done,
  output logic              wr_commit,
  output logic              wr_discard,
  output logic              busy,
  output logic              prot_flag
);
  hit_e hit;
  logic is_cmd, accept, cyc_end, auth, pend_set, pend_clr;

  wpd_matcher #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
    .clk(clk), .rst(rst), .restart(win_timeout), .byte_ev(accept),
    .addr(ld_addr), .data(ld_data), .hit(hit), .is_cmd(is_cmd)
  );

  wpd_window u_win (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .win_timeout(win_timeout),
    .cyc_done(cyc_done), .hit(hit), .accept(accept), .cyc_end(cyc_end),
    .busy(busy), .auth(auth), .pend_set(pend_set), .pend_clr(pend_clr)
  );

  wpd_flag u_flag (
    .clk(clk), .rst(rst), .prot_init(prot_init), .cyc_end(cyc_end),
    .pend_set(pend_set), .pend_clr(pend_clr), .prot_flag(prot_flag)
  );

  logic store_ok;
  assign store_ok = !is_cmd && (!prot_flag || auth);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_commit  <= 1'b0;
      wr_discard <= 1'b0;
    end else begin
      wr_commit  <= accept && store_ok;
      wr_discard <= accept && !store_ok;
    end
  end
endmodule

// File: rtl/wp_cmd_detect_chk.sv
module wp_cmd_detect_chk (
  input logic clk,
  input logic rst,
  input logic prot_init,
  input logic ld_valid,
  input logic win_timeout,
  input logic cyc_done,
  input logic wr_commit,
  input logic wr_discard,
  input logic busy,
  input logic prot_flag
);
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(wr_commit && wr_discard)); // R2
  AST_PULSE_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
    (wr_commit || wr_discard) |-> $past(ld_valid)); // R2
  AST_BUSY_IGNORES_LOAD: assert property (@(posedge clk) disable iff (rst)
    (busy && ld_valid) |=> !(wr_commit || wr_discard)); // R10
  AST_BUSY_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(win_timeout)); // R9
  AST_BUSY_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(cyc_done)); // R10
  AST_FLAG_AT_END: assert property (@(posedge clk) disable iff (rst)
    !$stable(prot_flag) |-> $past(cyc_done && busy)); // R8
  AST_FLAG_FROM_INIT: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (prot_flag == $past(prot_init))); // R1
endmodule

bind wp_cmd_detect wp_cmd_detect_chk u_chk (
  .clk(clk), .rst(rst), .prot_init(prot_init), .ld_valid(ld_valid),
  .win_timeout(win_timeout), .cyc_done(cyc_done), .wr_commit(wr_commit),
  .wr_discard(wr_discard), .busy(busy), .prot_flag(prot_flag)
);

// File: tb/wp_cmd_detect_bench.sv
module wp_cmd_detect_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic prot_init = 1'b1;
  logic ld_valid = 1'b0;
  logic [12:0] ld_addr = '0;
  logic [7:0] ld_data = '0;
  logic win_timeout = 1'b0;
  logic cyc_done = 1'b0;
  logic wr_commit, wr_discard, busy, prot_flag;

  always #4 clk = ~clk;

  wp_cmd_detect u_wp_cmd_detect (
    .clk(clk), .rst(rst), .prot_init(prot_init), .ld_valid(ld_valid),
    .ld_addr(ld_addr), .ld_data(ld_data), .win_timeout(win_timeout),
    .cyc_done(cyc_done), .wr_commit(wr_commit), .wr_discard(wr_discard),
    .busy(busy), .prot_flag(prot_flag)
  );

  int total = 0;
  int bad = 0;
  bit m_prot, m_busy, m_open, m_live, m_auth, m_set, m_clr;
  int m_step;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // 0 no match, 1 advance, 2 unlock done, 3 remove done
  function automatic int seq_step(input int st, input logic [12:0] a, input logic [7:0] d);
    logic [12:0] ea;
    logic [7:0] ed;
    if (st == 2 && a == 13'h1555 && d == 8'hA0) return 2;
    case (st)
      0, 3: begin ea = 13'h1555; ed = 8'hAA; end
      1, 4: begin ea = 13'h0AAA; ed = 8'h55; end
      2:    begin ea = 13'h1555; ed = 8'h80; end
      default: begin ea = 13'h1555; ed = 8'h20; end
    endcase
    if (a != ea || d != ed) return 0;
    return (st == 5) ? 3 : 1;
  endfunction

  function automatic bit want_commit(input bit cmd, input bit prot, input bit auth);
    return !cmd && (!prot || auth);
  endfunction

  task automatic model_reset();
    m_prot = prot_init; m_busy = 0; m_open = 0; m_live = 1;
    m_auth = 0; m_set = 0; m_clr = 0; m_step = 0;
  endtask

  task automatic load(input logic [12:0] a, input logic [7:0] d);
    bit cmd, ec, ed;
    int r;
    @(negedge clk);
    ld_valid = 1; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_valid = 0;
    cmd = 0;
    if (m_busy) begin
      ec = 0; ed = 0;
      chk(!wr_commit && !wr_discard, "R10 load while busy ignored",
          int'({wr_commit, wr_discard}), 0);
      return;
    end
    m_open = 1;
    if (m_live) begin
      r = seq_step(m_step, a, d);
      if (r == 0) m_live = 0;
      else begin
        cmd = 1;
        if (r == 1) m_step++;
        else begin
          m_live = 0; m_auth = 1;
          if (r == 2) m_set = 1; else m_clr = 1;
        end
      end
    end
    ec = want_commit(cmd, m_prot, m_auth && !cmd);
    if (cmd) ec = 0;
    else ec = want_commit(0, m_prot, m_auth);
    ed = !ec;
    chk(wr_commit == ec && wr_discard == ed,
        cmd ? "R3/R4 command byte discarded" :
        (m_prot ? "R7 protected user byte" : "R6/R5 unprotected user byte"),
        int'({wr_commit, wr_discard}), int'({ec, ed}));
  endtask

  task automatic timeout();
    @(negedge clk);
    win_timeout = 1;
    @(negedge clk);
    win_timeout = 0;
    if (m_open) begin m_busy = 1; m_open = 0; end
    m_step = 0; m_live = 1;
    chk(busy == m_busy, "R9 busy after timeout", busy, m_busy);
  endtask

  task automatic finish_cycle();
    chk(prot_flag == m_prot, "R8 flag held until cycle end", prot_flag, m_prot);
    @(negedge clk);
    cyc_done = 1;
    @(negedge clk);
    cyc_done = 0;
    if (m_busy) begin
      if (m_set) m_prot = 1; else if (m_clr) m_prot = 0;
      m_busy = 0; m_auth = 0; m_set = 0; m_clr = 0;
    end
    chk(busy == 0, "R10 busy cleared by done", busy, 0);
    chk(prot_flag == m_prot, "R8 flag after cycle end", prot_flag, m_prot);
  endtask

  task automatic unlock();
    load(13'h1555, 8'hAA); load(13'h0AAA, 8'h55); load(13'h1555, 8'hA0);
  endtask

  task automatic remove();
    load(13'h1555, 8'hAA); load(13'h0AAA, 8'h55); load(13'h1555, 8'h80);
    load(13'h1555, 8'hAA); load(13'h0AAA, 8'h55); load(13'h1555, 8'h20);
  endtask

  task automatic do_reset(input bit init);
    @(negedge clk);
    rst = 1; prot_init = init;
    repeat (3) @(negedge clk);
    rst = 0;
    model_reset();
    @(negedge clk);
    chk(prot_flag == init, "R1 flag from prot_init", prot_flag, init);
    chk(!busy && !wr_commit && !wr_discard, "R1 idle after reset",
        int'({busy, wr_commit, wr_discard}), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=1 exp=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd2024));
    do_reset(1'b1);
    do_reset(1'b0);
    // R6 plain data while unprotected
    load(13'h0010, 8'h3C); load(13'h0011, 8'hC3);
    timeout(); load(13'h0012, 8'h01); finish_cycle();
    // R9 timeout with no open window is ignored
    timeout();
    // R3 unlock alone sets the flag (R8)
    unlock(); timeout(); finish_cycle();
    // R7 protected without prefix: discarded, cycle still starts (R9)
    load(13'h0200, 8'h77); timeout(); finish_cycle();
    // R7 protected with prefix and data
    unlock(); load(13'h1555, 8'h99); load(13'h0AAA, 8'h11); timeout(); finish_cycle();
    // R5 break after two steps while protected
    load(13'h1555, 8'hAA); load(13'h0AAA, 8'h55); load(13'h1555, 8'h42);
    load(13'h1555, 8'hAA); timeout(); finish_cycle();
    // R11 timeout in the middle of the remove sequence
    load(13'h1555, 8'hAA); load(13'h0AAA, 8'h55); load(13'h1555, 8'h80);
    timeout(); finish_cycle();
    // R4 full remove with data clears flag
    remove(); load(13'h0005, 8'h5A); timeout(); finish_cycle();
    // R5 unprotected: broken sequence byte is data
    load(13'h1555, 8'hAA); load(13'h0123, 8'h55); timeout(); finish_cycle();
    // R4 remove while unprotected, no data
    remove(); timeout(); finish_cycle();
    // random windows
    for (int w = 0; w < 300; w++) begin
      int kind = $urandom_range(0, 4);
      int n = $urandom_range(0, 5);
      if (kind == 0) unlock();
      else if (kind == 1) remove();
      else if (kind == 2) begin
        load(13'h1555, 8'hAA);
        if ($urandom_range(0, 1) == 1) load(13'h0AAA, 8'h55);
      end
      for (int b = 0; b < n; b++) begin
        logic [12:0] a = ($urandom_range(0, 2) == 0) ? 13'h1555 : 13'($urandom);
        logic [7:0] d = ($urandom_range(0, 2) == 0) ? 8'hAA : 8'($urandom);
        load(a, d);
      end
      timeout();
      if ($urandom_range(0, 3) == 0) load(13'($urandom), 8'($urandom));
      finish_cycle();
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule